// File: doc/BRIEF.md
# Configurable Windowed Watchdog Timer

This block supervises software by counting a slow, free-running tick and raising a reset request when software fails to kick it in time. How it behaves is fixed while the system reset is held. At that point the block takes in a configuration word. The word holds a two-bit enable policy, a window-disable bit, a prescaler select and a four-bit postscaler select. After reset, the configuration inputs have no further effect. An unprogrammed word reads as all ones. That setting gives a watchdog that is always on, not windowed, uses the long prescaler and the longest postscaler.

The timeout is P x 2^N ticks. P is the prescale ratio and N is the postscaler select. A timeout while awake latches a reset request, which stays high until the system reset. A timeout during sleep, while the timer is still running, gives a one-cycle wake event instead. In windowed operation, a kick in the first three quarters of the period is treated as a fault and raises the reset request at once. A flag records that the watchdog has fired since the last system reset.

Top module: `cfg_watchdog`

## Requirements
- R1: The configuration fields are captured in every cycle with rst high and are held at all other times. Changing them after reset has no effect. The erased word (all ones) selects always-on, non-windowed, P = 2^PRE_HI_LOG2 and N = 15.
- R2: Enable code 2'b11 runs the timer whatever the values of sw_en and sleep_i.
- R3: Enable code 2'b10 runs the timer only while sw_en is 1. While sw_en is 0, the count is held at zero.
- R4: Enable code 2'b01 runs the timer only while sleep_i is 0 and ignores sw_en. In sleep the count is held at zero.
- R5: Enable code 2'b00 never produces wdt_rst_req or wake_evt. This holds even with cfg_win_off at 0 and early kicks.
- R6: A timeout occurs on the cycle with tick high that completes P x 2^N counted ticks. P is 2^PRE_HI_LOG2 when cfg_pre_sel is 1 and 2^PRE_LO_LOG2 when it is 0. Cycles with tick low are not counted.
- R7: A timeout with sleep_i low sets wdt_rst_req one clock after the completing tick. wdt_rst_req then stays high and the count freezes until rst.
- R8: A timeout with sleep_i high, while the timer runs, pulses wake_evt for exactly one cycle and restarts the count. It does not raise wdt_rst_req.
- R9: With cfg_win_off at 0, a kick while 4 x elapsed < 3 x (P x 2^N) sets wdt_rst_req on the next clock. A later kick restarts the count.
- R10: With cfg_win_off at 1, a kick at any point restarts the count and never raises a request.
- R11: A kick, a rise of sleep_i or a fall of sleep_i each restart the count from zero. A restart in the same cycle as a completing tick suppresses that timeout.
- R12: wdt_flag goes high with any reset request or wake event and is cleared only by rst.
- R13: While rst is high and on the cycle after it, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset; also captures the configuration |
| tick | input | 1 | One-cycle enable marking each slow-clock tick |
| sleep_i | input | 1 | High while the system is asleep |
| sw_en | input | 1 | Software enable, used by enable code 2'b10 |
| kick | input | 1 | Clear strobe from software |
| cfg_mode | input | 2 | Enable policy code |
| cfg_win_off | input | 1 | 1 = standard, 0 = windowed |
| cfg_pre_sel | input | 1 | 1 = long prescaler, 0 = short prescaler |
| cfg_post_sel | input | 4 | Postscaler exponent N |
| wdt_rst_req | output | 1 | Latched reset request |
| wake_evt | output | 1 | One-cycle wake from sleep |
| wdt_flag | output | 1 | Watchdog has fired since rst |

## Verification
Two cases can fall in the same cycle. In the first, a restart source (a kick or a sleep edge) lands on the very tick that completes the period. The bench provokes this by restarting with a kick and then applying the next kick, or a sleep toggle, exactly P x 2^N ticks later. A behavioural model that counts elapsed ticks in a single integer judges it: no request and no wake may appear. In the second case, a windowed kick arrives just before versus just after the three-quarter boundary. The model compares against that boundary every cycle.

// File: rtl/cwdt_pkg.sv
package cwdt_pkg;
  localparam int POST_SEL_W = 4;

  typedef enum logic [1:0] {
    EN_OFF    = 2'b00,
    EN_AWAKE  = 2'b01,
    EN_SOFT   = 2'b10,
    EN_ALWAYS = 2'b11
  } en_mode_e;

  typedef struct packed {
    en_mode_e                mode;
    logic                    win_off;
    logic                    pre_hi;
    logic [POST_SEL_W-1:0]   post_sel;
  } cfg_t;
endpackage

// File: rtl/cwdt_prescale.sv
module cwdt_prescale #(
  parameter int LO_LOG2 = 5,
  parameter int HI_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               en,
  input  logic               sel_hi,
  output logic [HI_LOG2-1:0] cnt,
  output logic               wrap
);
  localparam logic [HI_LOG2-1:0] LIM_HI = {HI_LOG2{1'b1}};
  localparam logic [HI_LOG2-1:0] LIM_LO = HI_LOG2'((1 << LO_LOG2) - 1);

  logic [HI_LOG2-1:0] limit;
  assign limit = sel_hi ? LIM_HI : LIM_LO;
  assign wrap  = en && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (en)     cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R6: prescale count never passes the selected ratio
  assert_pre_limit_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/cwdt_postscale.sv
module cwdt_postscale #(
  parameter int SEL_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      adv,
  input  logic [SEL_W-1:0]          sel,
  output logic [(1<<SEL_W)-2:0]     cnt,
  output logic                      done
);
  localparam int QW = (1 << SEL_W) - 1;
  localparam logic [QW-1:0] ONES = {QW{1'b1}};

  logic [QW-1:0] limit;
  assign limit = ~(ONES << sel);
  assign done  = adv && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (adv)    cnt <= done ? '0 : cnt + 1'b1;
  end

  // R6: postscale count stays below 2^N
  assert_post_limit_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/cwdt_window.sv
module cwdt_window #(
  parameter int LO_LOG2 = 5,
  parameter int HI_LOG2 = 7,
  parameter int SEL_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [HI_LOG2-1:0]        pre_cnt,
  input  logic [(1<<SEL_W)-2:0]     post_cnt,
  input  logic                      pre_hi,
  input  logic [SEL_W-1:0]          post_sel,
  output logic                      early
);
  localparam int QW = (1 << SEL_W) - 1;
  localparam int CW = HI_LOG2 + QW + 3;

  logic [CW-1:0] elapsed, total;
  int            shift;

  always_comb begin
    shift   = pre_hi ? HI_LOG2 : LO_LOG2;
    elapsed = (CW'(post_cnt) << shift) + CW'(pre_cnt);
    total   = CW'(1) << (shift + int'(post_sel));
    early   = (elapsed << 2) < (total + (total << 1));
  end

  // R9: elapsed ticks combined from both counters stay inside one period
  assert_win_range_R9: assert property (@(posedge clk) disable iff (rst)
    elapsed < total);
endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog
  import cwdt_pkg::*;
#(
  parameter int PRE_LO_LOG2 = 5,
  parameter int PRE_HI_LOG2 = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sleep_i,
  input  logic       sw_en,
  input  logic       kick,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_win_off,
  input  logic       cfg_pre_sel,
  input  logic [3:0] cfg_post_sel,
  output logic       wdt_rst_req,
  output logic       wake_evt,
  output logic       wdt_flag
);
  localparam int QW = (1 << POST_SEL_W) - 1;

  cfg_t cfg_q;
  logic sleep_q;
  logic run, hold, sleep_edge, restart, cnt_en;
  logic pre_wrap, post_done, early, fault, expire;
  logic [PRE_HI_LOG2-1:0] pre_cnt;
  logic [QW-1:0]          post_cnt;

  // Configuration captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mode     <= en_mode_e'(cfg_mode);
      cfg_q.win_off  <= cfg_win_off;
      cfg_q.pre_hi   <= cfg_pre_sel;
      cfg_q.post_sel <= cfg_post_sel;
      sleep_q        <= 1'b0;
    end else begin
      sleep_q        <= sleep_i;
    end
  end

  always_comb begin
    unique case (cfg_q.mode)
      EN_ALWAYS: run = 1'b1;
      EN_SOFT:   run = sw_en;
      EN_AWAKE:  run = !sleep_i;
      default:   run = 1'b0;
    endcase
  end

  assign hold       = wdt_rst_req;
  assign sleep_edge = sleep_i ^ sleep_q;
  assign restart    = !hold && (!run || kick || sleep_edge);
  assign cnt_en     = tick && run && !hold;

  cwdt_prescale #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk(clk), .rst(rst), .clr(restart), .en(cnt_en),
    .sel_hi(cfg_q.pre_hi), .cnt(pre_cnt), .wrap(pre_wrap));

  cwdt_postscale #(.SEL_W(POST_SEL_W)) u_post (
    .clk(clk), .rst(rst), .clr(restart), .adv(pre_wrap),
    .sel(cfg_q.post_sel), .cnt(post_cnt), .done(post_done));

  cwdt_window #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2), .SEL_W(POST_SEL_W)) u_win (
    .clk(clk), .rst(rst), .pre_cnt(pre_cnt), .post_cnt(post_cnt),
    .pre_hi(cfg_q.pre_hi), .post_sel(cfg_q.post_sel), .early(early));

  assign fault  = !hold && run && kick && !cfg_q.win_off && early;
  assign expire = post_done && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_rst_req <= 1'b0;
      wake_evt    <= 1'b0;
      wdt_flag    <= 1'b0;
    end else begin
      wake_evt <= expire && sleep_i;
      if (fault || (expire && !sleep_i)) wdt_rst_req <= 1'b1;
      if (fault || expire)               wdt_flag    <= 1'b1;
    end
  end

  // R7: a request, once raised, is held until reset
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |=> wdt_rst_req);
  // R8: wake is a single-cycle pulse issued from sleep
  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> !wake_evt);
  assert_wake_sleep_R8: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> $past(sleep_i));
  // R5: disabled policy never fires
  assert_off_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.mode == EN_OFF) |-> (!wdt_rst_req && !wake_evt));
  // R12: flag accompanies every event
  assert_flag_cover_R12: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst_req || wake_evt) |-> wdt_flag);
endmodule

// File: tb/cfg_watchdog_test.sv
module cfg_watchdog_test;
  localparam int LO = 2;
  localparam int HI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, sleep_i = 1'b0, sw_en = 1'b0, kick = 1'b0;
  logic [1:0] cfg_mode = 2'b11;
  logic cfg_win_off = 1'b1, cfg_pre_sel = 1'b1;
  logic [3:0] cfg_post_sel = 4'hF;
  logic wdt_rst_req, wake_evt, wdt_flag;

  cfg_watchdog #(.PRE_LO_LOG2(LO), .PRE_HI_LOG2(HI)) uut (
    .clk(clk), .rst(rst), .tick(tick), .sleep_i(sleep_i), .sw_en(sw_en),
    .kick(kick), .cfg_mode(cfg_mode), .cfg_win_off(cfg_win_off),
    .cfg_pre_sel(cfg_pre_sel), .cfg_post_sel(cfg_post_sel),
    .wdt_rst_req(wdt_rst_req), .wake_evt(wake_evt), .wdt_flag(wdt_flag));

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0, tc = 0, tick_div = 1;
  string tag = "R13";
  bit started = 0;

  // Reference model: elapsed ticks in one integer
  int  m_mode, m_post, m_el, m_total;
  bit  m_win_off, m_pre;
  bit  m_req = 0, m_wake = 0, m_flag = 0, m_ps = 0, m_run;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_mode = cfg_mode; m_win_off = cfg_win_off; m_pre = cfg_pre_sel;
      m_post = cfg_post_sel; m_el = 0;
      m_req = 0; m_wake = 0; m_flag = 0; m_ps = 0;
    end else begin
      m_total = 1 << ((m_pre ? HI : LO) + m_post);
      m_run = (m_mode == 3) || (m_mode == 2 && sw_en) || (m_mode == 1 && !sleep_i);
      m_wake = 0;
      if (!m_req) begin
        if (!m_run) m_el = 0;
        else if (kick) begin
          if (!m_win_off && (m_el * 4 < 3 * m_total)) begin m_req = 1; m_flag = 1; end
          m_el = 0;
        end else if (sleep_i != m_ps) m_el = 0;
        else if (tick) begin
          if (m_el + 1 == m_total) begin
            m_el = 0; m_flag = 1;
            if (sleep_i) m_wake = 1; else m_req = 1;
          end else m_el = m_el + 1;
        end
      end
      m_ps = sleep_i;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (wdt_rst_req !== m_req || wake_evt !== m_wake || wdt_flag !== m_flag) begin
        mismatched++;
        $display("FAIL %s t=%0t req/wake/flag actual=%b%b%b expected=%b%b%b",
                 tag, $time, wdt_rst_req, wake_evt, wdt_flag, m_req, m_wake, m_flag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog %s actual=%0d cycles expected<150000", tag, cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    tick = (tick_div <= 1) ? 1'b1 : ((tc % tick_div) == 0);
    tc++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset(input logic [1:0] md, input logic wo, input logic ps,
                          input logic [3:0] pst);
    rst = 1'b1; kick = 1'b0; sleep_i = 1'b0; sw_en = 1'b0;
    cfg_mode = md; cfg_win_off = wo; cfg_pre_sel = ps; cfg_post_sel = pst;
    steps(2);
    rst = 1'b0;
    // R1: scramble configuration inputs after reset
    cfg_mode = ~md; cfg_win_off = ~wo; cfg_pre_sel = ~ps; cfg_post_sel = ~pst;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; step(); kick = 1'b0;
  endtask

  initial begin
    // R13 / R1: erased word, long period, no event
    tag = "R13"; do_reset(2'b11, 1'b1, 1'b1, 4'hF);
    tag = "R1"; steps(300);

    // R6 / R7: short prescaler, N=2, tick every other cycle
    tag = "R6"; tick_div = 2; do_reset(2'b11, 1'b1, 1'b0, 4'd2);
    tag = "R7"; steps(60);
    // R6: long prescaler, N=1, tick every cycle
    tag = "R6"; tick_div = 1; do_reset(2'b11, 1'b1, 1'b1, 4'd1);
    steps(40);

    // R2 / R8: always-on in sleep with sw_en low -> wake pulses
    tag = "R2"; do_reset(2'b11, 1'b1, 1'b0, 4'd2);
    sleep_i = 1'b1; tag = "R8"; steps(70);
    sleep_i = 1'b0; tag = "R12"; steps(5);

    // R3: software-gated
    tag = "R3"; do_reset(2'b10, 1'b1, 1'b0, 4'd2);
    steps(50); sw_en = 1'b1; steps(30);

    // R4: awake-only, ignores sw_en
    tag = "R4"; do_reset(2'b01, 1'b1, 1'b0, 4'd2);
    sleep_i = 1'b1;
    for (int i = 0; i < 12; i++) begin sw_en = ~sw_en; steps(5); end
    sleep_i = 1'b0; steps(30);

    // R5: disabled, windowed bit clear, early kicks
    tag = "R5"; do_reset(2'b00, 1'b0, 1'b0, 4'd2);
    for (int i = 0; i < 30; i++) begin pulse_kick(); steps(2); end

    // R9: legal late kicks, then an early kick faults
    tag = "R9"; do_reset(2'b11, 1'b0, 1'b0, 4'd2);
    for (int i = 0; i < 3; i++) begin steps(14); pulse_kick(); end
    steps(5); pulse_kick(); steps(10);

    // R10: standard mode, frequent kicks
    tag = "R10"; do_reset(2'b11, 1'b1, 1'b0, 4'd2);
    for (int i = 0; i < 40; i++) begin steps(4); pulse_kick(); end
    steps(20);

    // R11: kick on the completing tick
    tag = "R11"; do_reset(2'b11, 1'b1, 1'b0, 4'd2);
    for (int i = 0; i < 4; i++) begin kick = 1'b1; step(); kick = 1'b0; steps(15); end
    // R11: sleep edge on the completing tick
    kick = 1'b1; step(); kick = 1'b0; steps(15);
    for (int i = 0; i < 4; i++) begin sleep_i = ~sleep_i; step(); steps(15); end
    steps(20);

    // R12: flag cleared only by reset
    tag = "R12"; do_reset(2'b11, 1'b1, 1'b0, 4'd0);
    steps(10);
    do_reset(2'b11, 1'b1, 1'b1, 4'hF); steps(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule